// File: doc/BRIEF.md
# Binomial delay-and-add prefilter

This block sits directly behind a single-bit sigma-delta modulator and turns its bitstream into a multi-bit sample stream using only adders and one-clock delay registers. It is a chain of identical stages. Each stage adds its input word to a copy of that word delayed by one clock. A chain of N such stages therefore applies a lowpass FIR whose weights are row N of Pascal's triangle, and no coefficient table is stored anywhere. Every full-rate stage widens the word by one bit and runs on every clock.

After the full-rate chain, an optional set of decimating stages can follow. Each one applies a [1,2,1] kernel and keeps one result for every two samples that reach it, so the rate halves and the word grows by two bits. The parameter NUM_STAGES (1 to 8) sets the number of full-rate stages and NUM_DEC (0 to 3) sets the number of decimating stages. All arithmetic is unsigned. A valid strobe marks the cycles whose sample depends only on real input bits (full-rate case) or on a fresh decimated result.

Top module: `binomial_prefilter`

## Requirements
- R1: While rst_n is low, and until the first rising clock edge at which rst_n is high, sample_out is 0 and sample_valid is 0.
- R2: With NUM_DEC = 0, edge t is the t-th rising edge at which rst_n is high, counting from 0, and x[i] is bit_in sampled at edge i, with x[i] = 0 for i < 0. After edge t, sample_out equals the sum over j = 0..N of C(N,j)·x[t−(N−1)−j].
- R3: With NUM_DEC = 0, sample_valid is low after edges 0 to 2N−2 and high after every edge from 2N−1 onward.
- R4: A long run of ones settles sample_out at exactly 2^N·4^D, where D = NUM_DEC. sample_out never exceeds that value, and its width is N+2D+1 bits.
- R5: A long run of zeros settles sample_out at 0.
- R6: Number the samples that reach a decimating stage u[0], u[1], and so on, counting only samples marked valid. For every even n ≥ 2, the stage emits u[n−2] + 2·u[n−1] + u[n], one clock after it receives u[n]. Between emissions its output holds its last value.
- R7: A decimating stage raises its valid output once for every two valid samples it receives. Since the full-rate stream arrives on every clock, the final valid strobe is never high on two consecutive cycles when NUM_DEC ≥ 1.
- R8: A single 1 in a stream of zeros reproduces the binomial row C(N,0) … C(N,N) on successive output cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one modulator bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Modulator output bit |
| sample_out | output | NUM_STAGES+2·NUM_DEC+1 | Filtered unsigned sample |
| sample_valid | output | 1 | High when sample_out holds a valid sample |

## Verification
In a decimating stage, the even-indexed sample that completes one output is also the first sample of the next output. Closing one result and opening the next therefore happen on the same clock. The bench provokes this with alternating patterns, with densities of one in four and three in four, with an isolated impulse and with random bits, which together place ones on both even and odd positions. Every cycle, a behavioural model that keeps its own sample history compares both the emitted sum and the valid strobe.

// File: rtl/binom_pkg.sv
// Shared limits and bus-layout helpers for the binomial prefilter.
// Assumes the full-rate stages sit first in the chain and the decimating stages follow.
package binom_pkg;
    localparam int MAX_STAGES = 8;
    localparam int MAX_DEC    = 3;

    // Width of the final sample for a given configuration.
    function automatic int sample_width(int n_stages, int n_dec);
        return 1 + n_stages + 2 * n_dec;
    endfunction

    // Bit offset of full-rate stage i output (width i+2) in the packed chain bus.
    function automatic int fr_offset(int i);
        return (i * (i + 3)) / 2;
    endfunction

    // Bit offset of decimating level l output (width fw+2l+2) in its packed bus.
    function automatic int dc_offset(int fw, int l);
        return l * fw + l * (l + 1);
    endfunction
endpackage

// File: rtl/binom_dly_add.sv
// One full-rate delay-and-add stage: dout = din + din delayed one clock.
// Runs on every clock regardless of din_vld. The valid flag only tracks when
// both taps have seen a valid input, so the reset zeros act as leading input.
module binom_dly_add #(
    parameter int IN_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] din,
    input  logic            din_vld,
    output logic [IN_W:0]   dout,
    output logic            dout_vld
);
    logic [IN_W-1:0] dly;
    logic            primed;

    // Delay register, registered sum and fill tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly      <= '0;
            dout     <= '0;
            primed   <= 1'b0;
            dout_vld <= 1'b0;
        end else begin
            dly      <= din;
            dout     <= {1'b0, din} + {1'b0, dly};
            primed   <= primed | din_vld;
            dout_vld <= din_vld & primed;
        end
    end
endmodule

// File: rtl/binom_dec121.sv
// Decimate-by-2 stage with a [1,2,1] kernel over its valid input samples.
// Counting valid inputs u[n], it emits u[n-2]+2u[n-1]+u[n] for each even n >= 2.
// Each even sample both closes one output and opens the next.
// The output register holds its value between emissions.
module binom_dec121 #(
    parameter int IN_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] din,
    input  logic            din_vld,
    output logic [IN_W+1:0] dout,
    output logic            dout_vld
);
    logic [IN_W-1:0] held;     // last even-indexed sample
    logic [IN_W+1:0] partial;  // held + 2 * odd sample
    logic            odd_next; // next valid sample has an odd index
    logic            primed;   // an even sample has been captured

    // Phase tracking, partial sum and emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= '0;
            partial  <= '0;
            odd_next <= 1'b0;
            primed   <= 1'b0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= 1'b0;
            if (din_vld) begin
                if (!odd_next) begin
                    if (primed) begin
                        dout     <= partial + {2'b00, din};
                        dout_vld <= 1'b1;
                    end
                    held     <= din;
                    primed   <= 1'b1;
                    odd_next <= 1'b1;
                end else begin
                    partial  <= {2'b00, held} + {1'b0, din, 1'b0};
                    odd_next <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/binomial_prefilter.sv
// Binomial prefilter top: NUM_STAGES full-rate delay-and-add stages, then
// NUM_DEC [1,2,1] decimate-by-2 stages. Stage outputs are packed into flat
// buses whose slices have the growing widths. Assumes one modulator bit per clock.
module binomial_prefilter #(
    parameter int NUM_STAGES = 4,
    parameter int NUM_DEC    = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bit_in,
    output logic [NUM_STAGES+2*NUM_DEC:0]   sample_out,
    output logic                            sample_valid
);
    localparam int OUT_W   = binom_pkg::sample_width(NUM_STAGES, NUM_DEC);
    localparam int FR_W    = NUM_STAGES + 1;
    localparam int FR_BITS = binom_pkg::fr_offset(NUM_STAGES);

    // Elaboration-time range checks on the configuration.
    if (NUM_STAGES < 1 || NUM_STAGES > binom_pkg::MAX_STAGES) begin : g_bad_stages
        $error("binomial_prefilter: NUM_STAGES out of range");
    end
    if (NUM_DEC < 0 || NUM_DEC > binom_pkg::MAX_DEC) begin : g_bad_dec
        $error("binomial_prefilter: NUM_DEC out of range");
    end

    logic [FR_BITS-1:0]    fr_bus;
    logic [NUM_STAGES-1:0] fr_vld;

    // Full-rate chain: stage i takes an (i+1)-bit word and returns (i+2) bits.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_fr
        localparam int IW = i + 1;
        logic [IW-1:0] st_in;
        logic          st_in_vld;
        if (i == 0) begin : g_src
            assign st_in     = bit_in;
            assign st_in_vld = 1'b1;
        end else begin : g_link
            assign st_in     = fr_bus[binom_pkg::fr_offset(i-1) +: IW];
            assign st_in_vld = fr_vld[i-1];
        end
        binom_dly_add #(.IN_W(IW)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (st_in),
            .din_vld  (st_in_vld),
            .dout     (fr_bus[binom_pkg::fr_offset(i) +: IW+1]),
            .dout_vld (fr_vld[i])
        );
    end

    // Output selection: straight from the full-rate chain, or through the decimators.
    if (NUM_DEC == 0) begin : g_nodec
        assign sample_out   = fr_bus[binom_pkg::fr_offset(NUM_STAGES-1) +: OUT_W];
        assign sample_valid = fr_vld[NUM_STAGES-1];
    end else begin : g_dec
        localparam int DC_BITS = binom_pkg::dc_offset(FR_W, NUM_DEC);
        logic [DC_BITS-1:0] dc_bus;
        logic [NUM_DEC-1:0] dc_vld;

        for (genvar l = 0; l < NUM_DEC; l++) begin : g_lvl
            localparam int IW = FR_W + 2 * l;
            logic [IW-1:0] lv_in;
            logic          lv_in_vld;
            if (l == 0) begin : g_src
                assign lv_in     = fr_bus[binom_pkg::fr_offset(NUM_STAGES-1) +: FR_W];
                assign lv_in_vld = fr_vld[NUM_STAGES-1];
            end else begin : g_link
                assign lv_in     = dc_bus[binom_pkg::dc_offset(FR_W, l-1) +: IW];
                assign lv_in_vld = dc_vld[l-1];
            end
            binom_dec121 #(.IN_W(IW)) u_dec (
                .clk      (clk),
                .rst_n    (rst_n),
                .din      (lv_in),
                .din_vld  (lv_in_vld),
                .dout     (dc_bus[binom_pkg::dc_offset(FR_W, l) +: IW+2]),
                .dout_vld (dc_vld[l])
            );
        end

        assign sample_out   = dc_bus[binom_pkg::dc_offset(FR_W, NUM_DEC-1) +: OUT_W];
        assign sample_valid = dc_vld[NUM_DEC-1];
    end
endmodule

// File: rtl/binomial_prefilter_chk.sv
// Property checker for binomial_prefilter, attached with bind below.
// Observes only the top-level ports. It keeps its own count of cycles since
// reset so that the fill window does not depend on a deep $past.
module binomial_prefilter_chk #(
    parameter int NUM_STAGES = 4,
    parameter int NUM_DEC    = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_STAGES+2*NUM_DEC:0] sample_out,
    input  logic                          sample_valid
);
    localparam int     FILL  = 2 * NUM_STAGES;
    localparam int     CNT_W = $clog2(FILL + 1);
    localparam longint FULL  = longint'(1) << (NUM_STAGES + 2 * NUM_DEC);

    logic [CNT_W-1:0] since_rst;

    // Saturating count of clock edges since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != CNT_W'(FILL))
            since_rst <= since_rst + CNT_W'(1);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (sample_valid == 1'b0 && sample_out == '0));

    // R3
    fill_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (since_rst == CNT_W'(FILL)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        longint'(sample_out) <= FULL);

    if (NUM_DEC == 0) begin : g_fr_props
        // R3
        fill_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == CNT_W'(FILL)) |-> sample_valid);
    end else begin : g_dec_props
        // R7
        dec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sample_valid |=> !sample_valid);
        // R6
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sample_valid |-> $stable(sample_out));
    end
endmodule

bind binomial_prefilter binomial_prefilter_chk #(
    .NUM_STAGES (NUM_STAGES),
    .NUM_DEC    (NUM_DEC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_out   (sample_out),
    .sample_valid (sample_valid)
);

// File: tb/binomial_prefilter_tb.sv
// Bench: three configurations fed the same bitstream, each compared every clock
// with a behavioural model built from a bit history and the binomial coefficients.
module binomial_prefilter_tb;
    localparam int CLK_P = 10;
    localparam int NCFG  = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_in;
    logic [6:0] a_out;  logic a_v;   // N=4, D=1
    logic [3:0] b_out;  logic b_v;   // N=3, D=0
    logic [6:0] c_out;  logic c_v;   // N=2, D=2

    int checks = 0;
    int errors = 0;

    int    xs[$];
    int    lv_val [NCFG][4];
    bit    lv_vld [NCFG][4];
    int    h0 [NCFG][4];
    int    h1 [NCFG][4];
    int    ncnt [NCFG][4];
    string tag_fr;

    always #(CLK_P/2) clk = ~clk;

    binomial_prefilter u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .sample_out(a_out), .sample_valid(a_v));
    binomial_prefilter #(.NUM_STAGES(3), .NUM_DEC(0)) u_dut_fr (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .sample_out(b_out), .sample_valid(b_v));
    binomial_prefilter #(.NUM_STAGES(2), .NUM_DEC(2)) u_dut_d2 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .sample_out(c_out), .sample_valid(c_v));

    function automatic int ns(int c);
        return (c == 0) ? 4 : (c == 1) ? 3 : 2;
    endfunction

    function automatic int ds(int c);
        return (c == 0) ? 1 : (c == 1) ? 0 : 2;
    endfunction

    function automatic int binom(int n, int k);
        int r = 1;
        for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
        return r;
    endfunction

    // Full-rate reference: binomial convolution over the bit history (R2).
    function automatic int fr_sum(int n, int t);
        int s = 0;
        for (int j = 0; j <= n; j++) begin
            int idx = t - (n - 1) - j;
            if (idx >= 0) s += binom(n, j) * xs[idx];
        end
        return s;
    endfunction

    // Advance every model by one clock edge; decimators consume the old upstream value.
    task automatic model_edge();
        int t = xs.size() - 1;
        for (int c = 0; c < NCFG; c++) begin
            for (int l = ds(c); l >= 1; l--) begin
                if (lv_vld[c][l-1]) begin
                    int u = lv_val[c][l-1];
                    if (ncnt[c][l] % 2 == 0 && ncnt[c][l] >= 2) begin
                        lv_val[c][l] = h1[c][l] + 2 * h0[c][l] + u;
                        lv_vld[c][l] = 1'b1;
                    end else begin
                        lv_vld[c][l] = 1'b0;
                    end
                    h1[c][l] = h0[c][l];
                    h0[c][l] = u;
                    ncnt[c][l]++;
                end else begin
                    lv_vld[c][l] = 1'b0;
                end
            end
            lv_val[c][0] = fr_sum(ns(c), t);
            lv_vld[c][0] = (t >= 2 * ns(c) - 1);
        end
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s t=%0d got %0d expected %0d", tag, xs.size() - 1, got, exp);
        end
    endtask

    // Per-cycle comparison of one configuration against its model.
    task automatic cmp(input int c, input int got, input bit gv);
        int    d = ds(c);
        string dtag;
        string vtag;
        if (d == 0) begin dtag = tag_fr; vtag = "R3"; end
        else        begin dtag = "R6";   vtag = "R7"; end
        chk($sformatf("%s cfg%0d data", dtag, c), got, lv_val[c][d]);
        chk($sformatf("%s cfg%0d valid", vtag, c), int'(gv), int'(lv_vld[c][d]));
    endtask

    // Drive one bit at the falling edge, let the rising edge take it, compare at the next fall.
    task automatic step(input bit b);
        bit_in = b;
        @(posedge clk);
        xs.push_back(int'(b));
        model_edge();
        @(negedge clk);
        cmp(0, int'(a_out), a_v);
        cmp(1, int'(b_out), b_v);
        cmp(2, int'(c_out), c_v);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_P * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        bit_in = 1'b0;
        tag_fr = "R2";
        repeat (3) @(negedge clk);
        // R1: outputs idle while reset is held
        chk("R1 a_out", int'(a_out), 0); chk("R1 a_v", int'(a_v), 0);
        chk("R1 b_out", int'(b_out), 0); chk("R1 b_v", int'(b_v), 0);
        chk("R1 c_out", int'(c_out), 0); chk("R1 c_v", int'(c_v), 0);
        rst_n = 1'b1;
        #1;
        chk("R1 a_v after release", int'(a_v), 0);

        tag_fr = "R5";
        repeat (30) step(1'b0);
        chk("R5 zeros a", int'(a_out), 0);
        chk("R5 zeros b", int'(b_out), 0);
        chk("R5 zeros c", int'(c_out), 0);

        tag_fr = "R4";
        repeat (40) step(1'b1);
        chk("R4 full scale b", int'(b_out), 8);
        chk("R4 full scale a", int'(a_out), 64);
        chk("R4 full scale c", int'(c_out), 64);
        chk("R4 b valid", int'(b_v), 1);

        tag_fr = "R5";
        repeat (30) step(1'b0);
        chk("R5 settle b", int'(b_out), 0);
        chk("R5 settle c", int'(c_out), 0);

        tag_fr = "R8";
        step(1'b1);
        repeat (24) step(1'b0);

        tag_fr = "R2";
        for (int i = 0; i < 60; i++)  step(bit'(i % 2));
        for (int i = 0; i < 80; i++)  step(bit'(i % 4 == 0));
        for (int i = 0; i < 80; i++)  step(bit'(i % 4 != 0));
        for (int i = 0; i < 600; i++) step(bit'($urandom % 2));

        summary();
        $finish;
    end
endmodule